// File: doc/BRIEF.md
# Flash Write Status Flag Generator

This block produces the byte a parallel NOR-style flash device returns on a read while its embedded program or erase algorithm runs. When no algorithm is active, the true array byte passes through. While an operation is busy, the read byte is replaced by a status pattern:

- bit 7 reports completion (polarity set per operation);
- bit 6 flips on every read access;
- bit 5 reports that the time limit has been exceeded;
- bit 3 distinguishes erase from program.

The memory array, command decoder and algorithm timing sit outside the block. They present the operation state, the most significant bit of the byte being programmed, a flag marking reads inside the erase-suspended sector, and the array byte.

Read accesses are seen as falling edges of the active-low output-enable strobe, sampled by the system clock. The read byte is registered and is due one clock after its inputs are sampled.

Operation state encoding on `op_state`:

| Code | State |
|------|-------|
| 0 | idle |
| 1 | program |
| 2 | erase |
| 3 | erase suspended |
| 4 | program timed out |
| 5 | erase timed out |
| 6 | program while erase suspended |

Code 7 is treated as idle.

Top module: `flash_status_gen`

## Requirements
- R1: While `rst` is high, `rd_data` reads 0 on the following clock, and the toggle bit state returns to 0.
- R2: With `op_state` idle (code 0 or 7), or erase suspended (code 3) with `in_susp_sector` low, `rd_data` equals `arr_data`.
- R3: With `op_state` program (code 1), bit 7 of `rd_data` is the inverse of `prog_data_msb`, and bits 5 and 3 read 0.
- R4: With `op_state` erase (code 2), bit 7 reads 0, bit 5 reads 0 and bit 3 reads 1.
- R5: In codes 1, 2, 4, 5 and 6, bit 6 inverts once for each clock in which `rd_strobe_n` is sampled low after being sampled high. It holds its value in every other clock.
- R6: In program timed out (code 4), bit 7 is the inverse of `prog_data_msb` and bit 3 reads 0. In erase timed out (code 5), bit 7 reads 0 and bit 3 reads 1. In both, bit 5 reads 1 and bit 6 keeps flipping.
- R7: In erase suspended (code 3) with `in_susp_sector` high, bit 7 reads 1, bits 5 and 3 read 0, and bit 6 holds its last value whatever the strobe does.
- R8: In program while erase suspended (code 6), bit 7 is the inverse of `prog_data_msb`, bits 5 and 3 read 1, and bit 6 flips on each read.
- R9: Whenever a status pattern is shown, bits 0, 1, 2 and 4 of `rd_data` read 0.
- R10: When `op_state` enters code 1, 2 or 6 from any other code, the toggle bit is cleared before that clock's read edge is applied. A first read in that clock therefore shows bit 6 = 1.
- R11: `rd_data` reflects the inputs sampled at the previous rising clock edge, with exactly one clock of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| op_state | input | 3 | Current algorithm state (see encoding) |
| prog_data_msb | input | 1 | Bit 7 of the byte being programmed |
| in_susp_sector | input | 1 | Read address lies in the erase-suspended sector |
| arr_data | input | DATA_W | True array byte for the read address |
| rd_strobe_n | input | 1 | Active-low output enable; a falling edge is a read access |
| rd_data | output | DATA_W | Registered read byte |

## Verification
Every result, including each toggle flip, is due exactly one rising edge after the inputs are applied. The edge detector and the output register share that edge, so a read strobe that falls before edge k is visible in bit 6 after edge k.

The bench drives its inputs on falling clock edges and stamps each expected byte with the cycle number at which it becomes due. The monitor compares only items whose due cycle has arrived, sampling on the falling edge. This keeps the comparison one cycle behind the stimulus without depending on process order.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_PROG      = 3'd1,
    OP_ERASE     = 3'd2,
    OP_SUSP      = 3'd3,
    OP_PROG_TO   = 3'd4,
    OP_ERASE_TO  = 3'd5,
    OP_SUSP_PROG = 3'd6,
    OP_SPARE     = 3'd7
  } op_e;

  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;
  localparam int LIMIT_BIT  = 5;
  localparam int KIND_BIT   = 3;

  function automatic logic op_toggles(op_e op);
    return op inside {OP_PROG, OP_ERASE, OP_PROG_TO, OP_ERASE_TO, OP_SUSP_PROG};
  endfunction

  function automatic logic op_starts(op_e op);
    return op inside {OP_PROG, OP_ERASE, OP_SUSP_PROG};
  endfunction
endpackage

// File: rtl/fsg_strobe_edge.sv
module fsg_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic fall
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b1;
    else     strobe_q <= strobe_n;
  end

  assign fall = strobe_q & ~strobe_n;
endmodule

// File: rtl/fsg_toggle_ctl.sv
module fsg_toggle_ctl
  import fsg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  op_e  op,
  input  logic rd_fall,
  output logic tog_next
);
  op_e  op_q;
  logic tog_q;
  logic start;
  logic tog_base;

  assign start    = op_starts(op) && (op != op_q);
  assign tog_base = start ? 1'b0 : tog_q;
  assign tog_next = tog_base ^ (rd_fall & op_toggles(op));

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_IDLE;
      tog_q <= 1'b0;
    end else begin
      op_q  <= op;
      tog_q <= tog_next;
    end
  end

  // R5: a read edge during a busy state, with no new start, flips the bit
  assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_fall && op_toggles(op) && !start) |=> (tog_q != $past(tog_q)));

  // R5, R7: no read edge and no start leaves the bit untouched
  assert_toggle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!rd_fall && !start) |=> $stable(tog_q));

  // R10: a start without a read edge leaves the bit cleared
  assert_toggle_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (start && !rd_fall) |=> (tog_q == 1'b0));
endmodule

// File: rtl/fsg_status_mux.sv
module fsg_status_mux
  import fsg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic              prog_msb,
  input  logic              in_susp,
  input  logic              tog,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] nxt_data,
  output logic              status_sel
);
  logic poll_v, limit_v, kind_v;

  always_comb begin
    status_sel = 1'b1;
    poll_v     = 1'b0;
    limit_v    = 1'b0;
    kind_v     = 1'b0;
    unique case (op)
      OP_PROG:      poll_v = ~prog_msb;
      OP_ERASE:     kind_v = 1'b1;
      OP_PROG_TO:   begin poll_v = ~prog_msb; limit_v = 1'b1; end
      OP_ERASE_TO:  begin limit_v = 1'b1; kind_v = 1'b1; end
      OP_SUSP_PROG: begin poll_v = ~prog_msb; limit_v = 1'b1; kind_v = 1'b1; end
      OP_SUSP:      begin status_sel = in_susp; poll_v = 1'b1; end
      default:      status_sel = 1'b0;
    endcase

    if (status_sel) begin
      nxt_data             = '0;
      nxt_data[POLL_BIT]   = poll_v;
      nxt_data[TOGGLE_BIT] = tog;
      nxt_data[LIMIT_BIT]  = limit_v;
      nxt_data[KIND_BIT]   = kind_v;
    end else begin
      nxt_data = arr_data;
    end
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_state,
  input  logic              prog_data_msb,
  input  logic              in_susp_sector,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              rd_strobe_n,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [DATA_W-1:0] RSVD_MASK = DATA_W'(8'h17);

  op_e               op;
  logic              rd_fall;
  logic              tog_next;
  logic              status_sel;
  logic [DATA_W-1:0] nxt_data;

  assign op = op_e'(op_state);

  fsg_strobe_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (rd_strobe_n),
    .fall     (rd_fall)
  );

  fsg_toggle_ctl u_tog (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .rd_fall  (rd_fall),
    .tog_next (tog_next)
  );

  fsg_status_mux #(.DATA_W(DATA_W)) u_mux (
    .op         (op),
    .prog_msb   (prog_data_msb),
    .in_susp    (in_susp_sector),
    .tog        (tog_next),
    .arr_data   (arr_data),
    .nxt_data   (nxt_data),
    .status_sel (status_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= nxt_data;
  end

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
    status_sel |=> ((rd_data & RSVD_MASK) == '0));

  assert_idle_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_IDLE) |=> (rd_data == $past(arr_data)));

  assert_prog_poll_R3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PROG) |=> (rd_data[POLL_BIT] == !$past(prog_data_msb)
                         && !rd_data[KIND_BIT] && !rd_data[LIMIT_BIT]));

  assert_erase_flags_R4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ERASE) |=> (!rd_data[POLL_BIT] && rd_data[KIND_BIT] && !rd_data[LIMIT_BIT]));

  assert_timeout_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (op inside {OP_PROG_TO, OP_ERASE_TO}) |=> rd_data[LIMIT_BIT]);

  assert_susp_sector_R7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUSP && in_susp_sector) |=> (rd_data[POLL_BIT] && !rd_data[LIMIT_BIT]
                                           && !rd_data[KIND_BIT]));

  assert_susp_prog_R8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUSP_PROG) |=> (rd_data[LIMIT_BIT] && rd_data[KIND_BIT]
                              && rd_data[POLL_BIT] == !$past(prog_data_msb)));
endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        op_state = 3'd0;
  logic              prog_data_msb = 1'b0;
  logic              in_susp_sector = 1'b0;
  logic [DATA_W-1:0] arr_data = '0;
  logic              rd_strobe_n = 1'b1;
  logic [DATA_W-1:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    logic [7:0]  exp;
    string       tag;
  } item_t;
  item_t sb[$];

  // reference state
  logic       m_tog = 1'b0;
  logic       m_prev_stb = 1'b1;
  logic [2:0] m_prev_op = 3'd0;

  flash_status_gen #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .op_state(op_state), .prog_data_msb(prog_data_msb),
    .in_susp_sector(in_susp_sector), .arr_data(arr_data),
    .rd_strobe_n(rd_strobe_n), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] model(input logic [2:0] op, input logic msb,
                                       input logic ins, input logic [7:0] arr,
                                       input logic tg);
    logic [7:0] r;
    r = 8'h00;
    case (op)
      3'd1: begin r[7] = ~msb; r[6] = tg; end
      3'd2: begin r[6] = tg; r[3] = 1'b1; end
      3'd4: begin r[7] = ~msb; r[6] = tg; r[5] = 1'b1; end
      3'd5: begin r[6] = tg; r[5] = 1'b1; r[3] = 1'b1; end
      3'd6: begin r[7] = ~msb; r[6] = tg; r[5] = 1'b1; r[3] = 1'b1; end
      3'd3: if (ins) begin r[7] = 1'b1; r[6] = tg; end else r = arr;
      default: r = arr;
    endcase
    return r;
  endfunction

  task automatic step(input logic [2:0] op, input logic msb, input logic ins,
                      input logic [7:0] arr, input logic stb, input string tag);
    item_t it;
    logic start, fall, busy;
    @(negedge clk);
    op_state = op; prog_data_msb = msb; in_susp_sector = ins;
    arr_data = arr; rd_strobe_n = stb;
    start = (op == 3'd1 || op == 3'd2 || op == 3'd6) && (op != m_prev_op);
    fall  = m_prev_stb && !stb;
    busy  = (op == 3'd1 || op == 3'd2 || op == 3'd4 || op == 3'd5 || op == 3'd6);
    if (start) m_tog = 1'b0;
    if (fall && busy) m_tog = ~m_tog;
    m_prev_op = op; m_prev_stb = stb;
    it.due = cyc + 1;
    it.exp = model(op, msb, ins, arr, m_tog);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // read cycle: one strobe low, then high
  task automatic rd(input logic [2:0] op, input logic msb, input logic ins,
                    input logic [7:0] arr, input string tag);
    step(op, msb, ins, arr, 1'b0, tag);
    step(op, msb, ins, arr, 1'b1, tag);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      n_cmp++;
      if (rd_data !== it.exp) begin
        n_bad++;
        $display("FAIL %s: rd_data=%h expected=%h (cycle %0d)", it.tag, rd_data, it.exp, cyc);
      end
    end
  end

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    arr_data = 8'hA5;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (rd_data !== 8'h00) begin
      n_bad++;
      $display("FAIL R1: rd_data=%h expected=00", rd_data);
    end
    rst = 1'b0;

    // R2, R11: idle pass-through, one-cycle latency on changing data
    step(3'd0, 1'b0, 1'b0, 8'h5A, 1'b1, "R2");
    step(3'd0, 1'b0, 1'b0, 8'hC3, 1'b1, "R11");
    rd(3'd0, 1'b1, 1'b0, 8'h3C, "R2");
    step(3'd7, 1'b0, 1'b0, 8'h99, 1'b1, "R2");

    // R3, R5, R10: program with bit7 of data = 1, several reads
    step(3'd1, 1'b1, 1'b0, 8'hFF, 1'b1, "R10");
    for (int i = 0; i < 4; i++) rd(3'd1, 1'b1, 1'b0, 8'hFF, "R5");
    // R5: strobe held low does not flip again
    step(3'd1, 1'b1, 1'b0, 8'hFF, 1'b0, "R5");
    step(3'd1, 1'b1, 1'b0, 8'hFF, 1'b0, "R5");
    step(3'd1, 1'b1, 1'b0, 8'hFF, 1'b0, "R5");
    step(3'd1, 1'b1, 1'b0, 8'hFF, 1'b1, "R3");
    // R6: program times out, toggle continues
    rd(3'd4, 1'b1, 1'b0, 8'hFF, "R6");
    rd(3'd4, 1'b1, 1'b0, 8'hFF, "R6");
    // completion: true data
    step(3'd0, 1'b0, 1'b0, 8'h80, 1'b1, "R2");

    // R10: new program with immediate read -> bit6 = 1; data msb = 0
    rd(3'd1, 1'b0, 1'b0, 8'h00, "R10");
    rd(3'd1, 1'b0, 1'b0, 8'h00, "R3");
    step(3'd0, 1'b0, 1'b0, 8'h12, 1'b1, "R2");

    // R4, R9: erase
    for (int i = 0; i < 3; i++) rd(3'd2, 1'b1, 1'b0, 8'hFF, "R4");
    rd(3'd5, 1'b0, 1'b0, 8'hFF, "R6");
    rd(3'd5, 1'b0, 1'b0, 8'hFF, "R9");

    // R7: suspend, inside sector: frozen toggle
    rd(3'd3, 1'b0, 1'b1, 8'h77, "R7");
    rd(3'd3, 1'b0, 1'b1, 8'h77, "R7");
    // R2: suspend, outside sector: array data
    rd(3'd3, 1'b0, 1'b0, 8'h6D, "R2");

    // R8: program during suspend
    step(3'd6, 1'b0, 1'b0, 8'h00, 1'b1, "R10");
    for (int i = 0; i < 3; i++) rd(3'd6, 1'b0, 1'b0, 8'h00, "R8");
    rd(3'd6, 1'b1, 1'b0, 8'h00, "R8");
    rd(3'd3, 1'b0, 1'b1, 8'h00, "R7");

    // resume erase starts fresh toggle
    rd(3'd2, 1'b0, 1'b0, 8'h00, "R10");

    // R1: reset mid-operation
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    n_cmp++;
    if (rd_data !== 8'h00) begin
      n_bad++;
      $display("FAIL R1: rd_data=%h expected=00 after mid-op reset", rd_data);
    end
    rst = 1'b0;
    m_tog = 1'b0; m_prev_stb = 1'b1; m_prev_op = 3'd0;
    rd_strobe_n = 1'b1; op_state = 3'd0;
    rd(3'd2, 1'b0, 1'b0, 8'h00, "R1");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule